// File: doc/BRIEF.md
# DMA Global Interrupt and Status Controller

This block is the shared control plane for a bank of DMA channels. It keeps a global control word (master enable, a fast-mode select bit, and two sticky error flags that gather address errors and halts from every channel). It keeps a per-channel interrupt-pending word, a per-channel fetch-busy word, and a per-channel programmable mask. Channels report completion, address-error and halt events on one-cycle strobes. The block turns these into pending bits and one registered interrupt line.

Software reaches the block through a simple single-cycle register port. A write of ones to the doorbell-set address sends a one-cycle start pulse to each selected channel, provided the master enable is on. The pending, busy and error-flag words are cleared by writing zeros to their bits. Writing ones leaves those bits as they are, so read-modify-write sequences are safe. A hardware event always beats a software clear that lands in the same cycle.

Top module: `dmac_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, and irq_o, dma_en_o and ch_start_o are low.
- R2: Control word at 0x1000: bit 0 (enable) and bit 31 (fast select) are read/write, and dma_en_o follows bit 0. Other bits other than 2 and 3 read zero.
- R3: Control bit 2 becomes set when any channel raises ch_addr_err_i, and bit 3 when any channel raises ch_halt_i. Writing 0 to such a bit clears it and writing 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the bit set.
- R4: Pending word at 0x1004, bit n: it becomes set when channel n raises any of ch_done_i, ch_addr_err_i or ch_halt_i.
- R5: A write to 0x1004 clears each pending bit written as 0 and keeps each bit written as 1. A channel event in the same cycle as the write leaves that channel's bit set.
- R6: irq_o is a register. It is high in the cycle after any pending bit is set, and low in the cycle after all pending bits are clear.
- R7: Writing to the doorbell-set address 0x100C with bit n at 1 drives ch_start_o[n] high for exactly the cycle after the write. Zero bits give no pulse, and the address reads zero.
- R8: While the enable bit is 0, doorbell-set writes produce no start pulse and set no busy bit.
- R9: Busy word at 0x1008, bit n: it becomes set by an accepted doorbell for channel n. It is cleared by any event of channel n, or by writing 0 to the bit. An accepted doorbell beats a clear in the same cycle.
- R10: Programmable mask at 0x101C: an NUM_CH-bit read/write word, and writing zero clears every channel.
- R11: Reads of an unmapped address return zero. Writes to one change no register and give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 13 | Byte address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| ch_done_i | input | NUM_CH | Per-channel completion strobe |
| ch_addr_err_i | input | NUM_CH | Per-channel address-error strobe |
| ch_halt_i | input | NUM_CH | Per-channel halt strobe |
| ch_start_o | output | NUM_CH | Per-channel descriptor-fetch start pulse |
| dma_en_o | output | 1 | Global enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can fall in the same cycle. A software write that clears pending, busy or error bits can arrive together with a channel event that sets them, and a doorbell accept can coincide with a channel event that clears busy. The bench provokes the pending case by sweeping every combination of prior pending state, clear mask and simultaneous event pattern on a four-channel build. Each result is compared with (old AND written) OR events, computed arithmetically. The error-flag and busy collisions are driven with chosen patterns and judged with the same set-over-clear rule.

// File: rtl/dmac_irq_pkg.sv
package dmac_irq_pkg;
  localparam int unsigned REG_AW = 13;

  localparam logic [REG_AW-1:0] OFS_CTRL = 13'h1000;
  localparam logic [REG_AW-1:0] OFS_PEND = 13'h1004;
  localparam logic [REG_AW-1:0] OFS_BUSY = 13'h1008;
  localparam logic [REG_AW-1:0] OFS_RING = 13'h100C;
  localparam logic [REG_AW-1:0] OFS_PROG = 13'h101C;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_AERR_BIT = 2;
  localparam int unsigned CTRL_HALT_BIT = 3;
  localparam int unsigned CTRL_FAST_BIT = 31;

  typedef struct packed {
    logic ctrl;
    logic pend;
    logic busy;
    logic ring;
    logic prog;
  } reg_sel_t;
endpackage

// File: rtl/dmac_reg_decode.sv
module dmac_reg_decode
  import dmac_irq_pkg::*;
(
  input  logic [REG_AW-1:0] addr_i,
  output reg_sel_t          sel_o
);
  always_comb begin
    sel_o      = '0;
    sel_o.ctrl = (addr_i == OFS_CTRL);
    sel_o.pend = (addr_i == OFS_PEND);
    sel_o.busy = (addr_i == OFS_BUSY);
    sel_o.ring = (addr_i == OFS_RING);
    sel_o.prog = (addr_i == OFS_PROG);
  end
endmodule

// File: rtl/dmac_flag_bank.sv
// Sticky bits: hardware set beats every clear; software clears by writing 0.
module dmac_flag_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] keep_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic sw_clr;
    assign sw_clr = wr_i && !keep_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q_o[i] <= 1'b0;
      else if (set_i[i])            q_o[i] <= 1'b1;
      else if (clr_i[i] || sw_clr)  q_o[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);                                        // R5
    AST_ZERO_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !keep_i[i] && !set_i[i]) |=> !q_o[i]);              // R5
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !clr_i[i] && !wr_i) |=> $stable(q_o[i]));      // R4
  end
endmodule

// File: rtl/dmac_ctrl_reg.sv
module dmac_ctrl_reg
  import dmac_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              aerr_any_i,
  input  logic              halt_any_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              en_o
);
  logic en_q, fast_q;
  logic [1:0] flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      fast_q <= 1'b0;
    end else if (wr_i) begin
      en_q   <= wdata_i[CTRL_EN_BIT];
      fast_q <= wdata_i[CTRL_FAST_BIT];
    end
  end

  dmac_flag_bank #(.WIDTH(2)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({halt_any_i, aerr_any_i}),
    .clr_i  (2'b00),
    .wr_i   (wr_i),
    .keep_i ({wdata_i[CTRL_HALT_BIT], wdata_i[CTRL_AERR_BIT]}),
    .q_o    (flags)
  );

  always_comb begin
    ctrl_o                = '0;
    ctrl_o[CTRL_EN_BIT]   = en_q;
    ctrl_o[CTRL_AERR_BIT] = flags[0];
    ctrl_o[CTRL_HALT_BIT] = flags[1];
    ctrl_o[CTRL_FAST_BIT] = fast_q;
  end
  assign en_o = en_q;

  AST_EN_TRACKS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (en_o == $past(wdata_i[CTRL_EN_BIT])));               // R2
  AST_AERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aerr_any_i |=> ctrl_o[CTRL_AERR_BIT]);                         // R3
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_any_i |=> ctrl_o[CTRL_HALT_BIT]);                         // R3
endmodule

// File: rtl/dmac_doorbell.sv
module dmac_doorbell #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              en_i,
  input  logic [NUM_CH-1:0] ring_i,
  output logic [NUM_CH-1:0] accept_o,
  output logic [NUM_CH-1:0] start_o
);
  assign accept_o = (wr_i && en_i) ? ring_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_o <= '0;
    else         start_o <= accept_o;
  end

  AST_RING_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |-> ($past(en_i) && $past(wr_i)));                  // R8
  AST_RING_ONLY_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && en_i) |=> (start_o == $past(ring_i)));                // R7
  AST_PULSE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (start_o == '0));                                    // R7
endmodule

// File: rtl/dmac_irq_ctrl.sv
module dmac_irq_ctrl
  import dmac_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] ch_done_i,
  input  logic [NUM_CH-1:0] ch_addr_err_i,
  input  logic [NUM_CH-1:0] ch_halt_i,
  output logic [NUM_CH-1:0] ch_start_o,
  output logic              dma_en_o,
  output logic              irq_o
);
  reg_sel_t           sel;
  logic [DATA_W-1:0]  ctrl_word;
  logic [NUM_CH-1:0]  ch_evt, pend_q, busy_q, prog_q, accept;
  logic [NUM_CH-1:0]  wmask;
  logic               irq_q;

  assign ch_evt = ch_done_i | ch_addr_err_i | ch_halt_i;
  assign wmask  = wdata_i[NUM_CH-1:0];

  dmac_reg_decode u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  dmac_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i && sel.ctrl),
    .wdata_i    (wdata_i),
    .aerr_any_i (|ch_addr_err_i),
    .halt_any_i (|ch_halt_i),
    .ctrl_o     (ctrl_word),
    .en_o       (dma_en_o)
  );

  dmac_flag_bank #(.WIDTH(NUM_CH)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ch_evt),
    .clr_i  ({NUM_CH{1'b0}}),
    .wr_i   (wr_i && sel.pend),
    .keep_i (wmask),
    .q_o    (pend_q)
  );

  dmac_doorbell #(.NUM_CH(NUM_CH)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i && sel.ring),
    .en_i     (dma_en_o),
    .ring_i   (wmask),
    .accept_o (accept),
    .start_o  (ch_start_o)
  );

  dmac_flag_bank #(.WIDTH(NUM_CH)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (accept),
    .clr_i  (ch_evt),
    .wr_i   (wr_i && sel.busy),
    .keep_i (wmask),
    .q_o    (busy_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 prog_q <= '0;
    else if (wr_i && sel.prog)   prog_q <= wmask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend_q;
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel.ctrl: rdata_o = ctrl_word;
      sel.pend: rdata_o[NUM_CH-1:0] = pend_q;
      sel.busy: rdata_o[NUM_CH-1:0] = busy_q;
      sel.prog: rdata_o[NUM_CH-1:0] = prog_q;
      default:  rdata_o = '0;
    endcase
  end

  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_q) |=> irq_o);                                          // R6
  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|pend_q) |=> !irq_o);                                        // R6
  AST_PEND_ON_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_evt) |=> ((pend_q & $past(ch_evt)) == $past(ch_evt)));    // R4
  AST_PROG_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel.prog) |=> (prog_q == $past(wmask)));              // R10
endmodule

// File: tb/sim_dmac_irq_ctrl.sv
module sim_dmac_irq_ctrl;
  localparam int N = 4;
  localparam logic [12:0] A_CTRL = 13'h1000, A_PEND = 13'h1004, A_BUSY = 13'h1008,
                          A_RING = 13'h100C, A_PROG = 13'h101C, A_HOLE = 13'h1010;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          wr = 1'b0;
  logic [12:0]   addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [N-1:0]  done = '0, aerr = '0, halt = '0, start;
  logic          irq, en;
  int            checks = 0, fails = 0;
  bit            finished = 1'b0;

  dmac_irq_ctrl #(.NUM_CH(N), .DATA_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ch_done_i(done), .ch_addr_err_i(aerr), .ch_halt_i(halt),
    .ch_start_o(start), .dma_en_o(en), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(logic w, logic [12:0] a, logic [31:0] d,
                      logic [N-1:0] dn, logic [N-1:0] er, logic [N-1:0] hl);
    wr = w; addr = a; wdata = d; done = dn; aerr = er; halt = hl;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; done = '0; aerr = '0; halt = '0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_PEND, v); chk("R1 pend", v, 0);
    rd(A_BUSY, v); chk("R1 busy", v, 0);
    rd(A_PROG, v); chk("R1 prog", v, 0);
    chk("R1 outs", {irq, en, start}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3: control word and sticky error flags
    step(1, A_CTRL, 32'hFFFF_FFFF, 0, 0, 0);
    rd(A_CTRL, v); chk("R2 ctrl rw", v, 32'h8000_0001);
    chk("R2 en", en, 1);
    step(0, A_CTRL, 0, 0, 4'b0100, 0);
    rd(A_CTRL, v); chk("R3 aerr set", v, 32'h8000_0005);
    step(0, A_CTRL, 0, 0, 0, 4'b0001);
    rd(A_CTRL, v); chk("R3 halt set", v, 32'h8000_000D);
    step(1, A_CTRL, 32'h8000_0009, 0, 0, 0);
    rd(A_CTRL, v); chk("R3 aerr clr", v, 32'h8000_0009);
    step(1, A_CTRL, 32'h8000_0001, 0, 0, 4'b1000);
    rd(A_CTRL, v); chk("R3 set wins", v, 32'h8000_0009);
    step(1, A_CTRL, 32'h8000_0001, 0, 0, 0);
    rd(A_CTRL, v); chk("R3 halt clr", v, 32'h8000_0001);

    // R4 / R5 / R6: exhaustive pending sweep
    for (int m = 0; m < 16; m++) begin
      for (int w = 0; w < 16; w++) begin
        for (int s = 0; s < 16; s++) begin
          logic [N-1:0] mm, ww, ss, ex;
          mm = m[N-1:0]; ww = w[N-1:0]; ss = s[N-1:0];
          step(1, A_PEND, 0, 0, 0, 0);
          step(0, A_PEND, 0, mm & 4'b0011, mm & 4'b0100, mm & 4'b1000);
          rd(A_PEND, v); chk("R4 pend set", v, {28'b0, mm});
          step(1, A_PEND, {28'b0, ww}, ss, 0, 0);
          ex = (mm & ww) | ss;
          rd(A_PEND, v); chk("R5 clr/set", v, {28'b0, ex});
          chk("R6 irq", irq, (mm != 0));
          step(1, A_PEND, 0, 0, 0, 0);
          chk("R6 irq next", irq, (ex != 0));
        end
      end
    end
    step(1, A_CTRL, 32'h0000_0001, 0, 0, 0);

    // R7 / R9: doorbell with enable on
    for (int p = 0; p < 16; p++) begin
      step(1, A_BUSY, 0, 0, 0, 0);
      step(1, A_RING, p, 0, 0, 0);
      chk("R7 pulse", start, p);
      rd(A_BUSY, v); chk("R9 busy set", v, p);
      rd(A_RING, v); chk("R7 ring reads 0", v, 0);
      step(0, A_RING, 0, 0, 0, 0);
      chk("R7 pulse end", start, 0);
    end
    step(1, A_BUSY, 0, 0, 0, 0);
    step(1, A_RING, 32'h3, 0, 0, 0);
    step(1, A_RING, 32'h4, 4'b0101, 0, 0);
    rd(A_BUSY, v); chk("R9 evt clr / ring wins", v, 32'h6);
    step(1, A_BUSY, 32'h4, 0, 0, 0);
    rd(A_BUSY, v); chk("R9 sw clr", v, 32'h4);
    step(0, A_BUSY, 0, 0, 0, 4'b0100);
    rd(A_BUSY, v); chk("R9 halt clr", v, 0);

    // R8: doorbell ignored while disabled
    step(1, A_CTRL, 0, 0, 0, 0);
    chk("R2 en off", en, 0);
    step(1, A_RING, 32'hF, 0, 0, 0);
    chk("R8 no pulse", start, 0);
    rd(A_BUSY, v); chk("R8 no busy", v, 0);

    // R10: programmable mask
    step(1, A_PROG, 32'hA, 0, 0, 0);
    rd(A_PROG, v); chk("R10 rw", v, 32'hA);
    step(1, A_PROG, 32'hFFFF_FFFF, 0, 0, 0);
    rd(A_PROG, v); chk("R10 width", v, 32'hF);
    step(1, A_PROG, 0, 0, 0, 0);
    rd(A_PROG, v); chk("R10 zero", v, 0);

    // R11: unmapped address
    step(1, A_PROG, 32'h5, 0, 0, 0);
    step(1, A_CTRL, 32'h1, 0, 0, 0);
    step(1, A_HOLE, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R11 no pulse", start, 0);
    step(1, 13'h0000, 32'h0, 0, 0, 0);
    rd(A_HOLE, v); chk("R11 reads 0", v, 0);
    rd(A_PROG, v); chk("R11 prog kept", v, 32'h5);
    rd(A_CTRL, v); chk("R11 ctrl kept", v, 32'h1);
    rd(A_BUSY, v); chk("R11 busy kept", v, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule